// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Shared Prescaler

This block holds an 8-bit count register that software can load and read back. It advances either on every instruction-cycle tick or on chosen edges of an external clock pin. Pin samples pass through a two-stage synchronizer before the edge is detected. One 8-bit prescaler is shared between two users. An ownership bit places it either in front of the counter or on a separate watchdog tick output. It is never placed on both.

All state moves only in clock cycles where the instruction-cycle enable is high. A write to the count register loads the new value at once. The two instruction cycles that follow do not increment the count. The write also clears the hidden prescaler count. When the count wraps from its top value to zero, a one-cycle overflow pulse is raised.

Top module: `tmr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the prescaler, the synchronizer and `ovf_pulse` clear to zero, so `rd_data` reads 0x00 after reset.
- R2: With `src_sel`=0 and `psc_to_wdt`=1, `rd_data` rises by exactly one at every clock edge where `cyc_en` is 1. At edges where `cyc_en` is 0, no state changes.
- R3: With `src_sel`=1, the pin is sampled into a two-stage synchronizer and compared with the previous synchronized sample. A rising edge counts when `edge_sel`=0 and a falling edge counts when `edge_sel`=1. A pin level that first appears at edge k is counted at edge k+2. A steady pin never counts.
- R4: With `psc_to_wdt`=0, the count advances once per 2^(`rate`+1) source ticks, where `rate` runs from 0 (divide by 2) to 7 (divide by 256).
- R5: With `psc_to_wdt`=1, the prescaler advances at every enabled cycle. `wdt_tick` is high in an enabled cycle when the low `rate` bits of the prescaler count are all ones, which gives a period of 2^`rate` cycles (divide by 1 to divide by 128). The counter sees undivided ticks.
- R6: With `wr_en`=1 at an enabled edge, `rd_data` takes `wr_data` at that edge. The count then holds through the next two enabled edges, and the prescaler count clears. Source ticks that arrive during those two cycles are dropped.
- R7: An increment from 0xFF gives 0x00 and drives `ovf_pulse` high for exactly the following cycle. A write never raises `ovf_pulse`.
- R8: `wdt_tick` stays 0 whenever `psc_to_wdt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable; all state updates are qualified by it |
| ext_pin | input | 1 | External clock pin, asynchronous |
| src_sel | input | 1 | 0 counts instruction cycles, 1 counts pin edges |
| edge_sel | input | 1 | 0 counts rising edges, 1 counts falling edges |
| psc_to_wdt | input | 1 | 0 puts the prescaler in front of the counter, 1 gives it to the watchdog tick |
| rate | input | 3 | Prescaler ratio select |
| wr_en | input | 1 | Count register write strobe |
| wr_data | input | 8 | Value to load into the count |
| rd_data | output | 8 | Current count |
| ovf_pulse | output | 1 | One-cycle pulse after a wrap to zero |
| wdt_tick | output | 1 | Prescaled tick for the watchdog path |

## Verification
The bench goes after the write-hold window. A design that drops only one cycle, or keeps counting in the prescaler during the hold, drifts by one step from the model right after each load. It checks pin edges with both polarities and with a pin held steady for a long time. A wrong synchronizer depth shows up as a count one edge early or late, and a level-sensitive detector shows up as a count that runs on a held pin. Rates 0 and 7 are hit for both owners of the prescaler. An off-by-one in the ratio decode halves or doubles the counting speed. Wraps from 0xFF are forced so that a missing or stretched overflow pulse is caught, and so that a pulse on a load is caught too.

// File: rtl/tmr_pkg.sv
// Package: shared widths and constants for the timer/counter block.
// Assumes an 8-bit count and an 8-bit prescaler with a 3-bit ratio field.
package tmr_pkg;
    localparam int CNT_W    = 8;
    localparam int PSC_W    = 8;
    localparam int RATE_W   = 3;
    localparam int SYNC_N   = 2;  // synchronizer depth in enabled cycles
    localparam int HOLD_CYC = 2;  // increments dropped after a write
    localparam int HOLD_W   = $clog2(HOLD_CYC + 1);
endpackage

// File: rtl/tmr_edge_sync.sv
// Module: brings the external pin into the clock domain through SYNC_N
// stages, then compares the last stage with its previous value to flag
// the selected edge. Assumes the pin is slow compared with cyc_en.
module tmr_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pin,
    input  logic fall,
    output logic edge_hit
);
    logic [SYNC_N-1:0] stg;
    logic              prev;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n)  stg[0] <= 1'b0;
        else if (en) stg[0] <= pin;
    end

    // Later stages shift the sample along.
    genvar g;
    generate
        for (g = 1; g < SYNC_N; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)  stg[g] <= 1'b0;
                else if (en) stg[g] <= stg[g-1];
            end
        end
    endgenerate

    // Keeps the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)  prev <= 1'b0;
        else if (en) prev <= stg[SYNC_N-1];
    end

    // Picks the rising or falling transition.
    always_comb edge_hit = fall ? (~stg[SYNC_N-1] & prev) : (stg[SYNC_N-1] & ~prev);

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en && edge_hit |=> prev != $past(prev)); // R3
endmodule

// File: rtl/tmr_prescaler.sv
// Module: hidden binary prescaler shared by the counter and the watchdog
// path. When owned by the counter it steps on source ticks and emits a
// pulse every 2^(rate+1) ticks. When owned by the watchdog it steps every
// enabled cycle and emits a tick every 2^rate cycles.
module tmr_prescaler #(
    parameter int PSC_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic              to_wdt,
    input  logic              adv,
    input  logic [RATE_W-1:0] rate,
    output logic              tmr_pulse,
    output logic              wdt_tick
);
    localparam logic [PSC_W-1:0] ONES = {PSC_W{1'b1}};

    logic [PSC_W-1:0] pc;
    logic [PSC_W-1:0] mask_t;
    logic [PSC_W-1:0] mask_w;

    // Ratio masks: the low rate+1 bits for the counter, the low rate bits for the watchdog.
    always_comb begin
        mask_t = ONES >> (PSC_W - 1 - int'(rate));
        mask_w = ONES >> (PSC_W - int'(rate));
    end

    // Prescaler count: clears on a write and steps for its current owner.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc <= '0;
        else if (en) begin
            if (clr)                pc <= '0;
            else if (to_wdt || adv) pc <= pc + 1'b1;
        end
    end

    // Output decode for each owner.
    always_comb begin
        tmr_pulse = en & ~to_wdt & ~clr & adv & ((pc & mask_t) == mask_t);
        wdt_tick  = en & to_wdt & ((pc & mask_w) == mask_w);
    end

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_pulse && wdt_tick)); // R8
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en && clr |=> pc == '0); // R6
endmodule

// File: rtl/tmr_unit.sv
// Module: top of the timer/counter. Selects the source, routes the source
// through or around the prescaler, applies the hold window after a write,
// and flags wraps. Assumes cyc_en marks instruction cycles in clk.
module tmr_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              ext_pin,
    input  logic              src_sel,
    input  logic              edge_sel,
    input  logic              psc_to_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              ovf_pulse,
    output logic              wdt_tick
);
    logic [CNT_W-1:0]  cnt;
    logic [HOLD_W-1:0] hold;
    logic              pin_edge;
    logic              src_tick;
    logic              adv;
    logic              psc_pulse;
    logic              inc;
    logic              wr;
    logic              ovf_q;

    tmr_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .en(cyc_en), .pin(ext_pin),
        .fall(edge_sel), .edge_hit(pin_edge)
    );

    tmr_prescaler #(.PSC_W(PSC_W), .RATE_W(RATE_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .en(cyc_en), .clr(wr), .to_wdt(psc_to_wdt),
        .adv(adv), .rate(rate), .tmr_pulse(psc_pulse), .wdt_tick(wdt_tick)
    );

    // Source tick, hold gating and the final increment decision.
    always_comb begin
        wr       = cyc_en & wr_en;
        src_tick = src_sel ? pin_edge : 1'b1;
        adv      = cyc_en & ~wr & (hold == '0) & src_tick;
        inc      = psc_to_wdt ? adv : psc_pulse;
    end

    // Count register: a write wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wr)   cnt <= wr_data;
        else if (inc)  cnt <= cnt + 1'b1;
    end

    // Hold window counter started by each write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    hold <= '0;
        else if (wr)                   hold <= HOLD_W'(HOLD_CYC);
        else if (cyc_en && hold != '0) hold <= hold - 1'b1;
    end

    // One-cycle overflow flag on a wrap from the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= inc & (cnt == {CNT_W{1'b1}});
    end

    assign rd_data   = cnt;
    assign ovf_pulse = ovf_q;

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && wr_en |=> rd_data == $past(wr_data)); // R6
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en && !wr_en && hold != '0 |=> $stable(rd_data)); // R6
    AST_IDLE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> $stable(rd_data) && !ovf_pulse); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_en && wr_en) |=> rd_data == $past(rd_data) || rd_data == $past(rd_data) + 1'b1); // R2
    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> rd_data == '0); // R7
    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse); // R7
endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0, src_sel = 1'b0, edge_sel = 1'b0;
    logic       psc_to_wdt = 1'b1, wr_en = 1'b0;
    logic [2:0] rate = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       ovf_pulse, wdt_tick;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    tmr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .src_sel(src_sel), .edge_sel(edge_sel), .psc_to_wdt(psc_to_wdt),
        .rate(rate), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ovf_pulse(ovf_pulse), .wdt_tick(wdt_tick)
    );

    // Reference model built from the requirements.
    logic [7:0] m_cnt = 0, m_pc = 0;
    logic       m_s1 = 0, m_s2 = 0, m_s3 = 0, m_ovf = 0;
    int         m_hold = 0;

    function automatic logic low_ones(input logic [7:0] v, input int nbits);
        logic [8:0] m;
        m = (9'd1 << nbits) - 9'd1;
        return (v & m[7:0]) == m[7:0];
    endfunction

    function automatic logic exp_wdt();
        return cyc_en && psc_to_wdt && low_ones(m_pc, int'(rate));
    endfunction

    always @(posedge clk) begin
        logic tick, inc;
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ovf = 0; m_hold = 0;
        end else if (!cyc_en) begin
            m_ovf = 0;
        end else begin
            m_ovf = 0;
            tick = !src_sel ? 1'b1 : (edge_sel ? (!m_s2 && m_s3) : (m_s2 && !m_s3));
            if (wr_en) begin
                m_cnt = wr_data; m_hold = 2; m_pc = 0;
            end else begin
                inc = 0;
                if (m_hold > 0) m_hold--;
                else if (tick) begin
                    if (psc_to_wdt) inc = 1;
                    else begin
                        inc = low_ones(m_pc, int'(rate) + 1);
                        m_pc++;
                    end
                end
                if (psc_to_wdt) m_pc++;
                if (inc) begin
                    m_ovf = (m_cnt == 8'hFF);
                    m_cnt++;
                end
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string cnt_tag();
        return src_sel ? "R3 count" : (psc_to_wdt ? "R2 count" : "R4 count");
    endfunction

    // Advance one edge, then compare all outputs with the model away from the edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(rd_data == m_cnt, cnt_tag(), rd_data, m_cnt);
        chk(ovf_pulse == m_ovf, "R7 ovf", ovf_pulse, m_ovf);
        chk(wdt_tick == exp_wdt(), psc_to_wdt ? "R5 wdt_tick" : "R8 wdt_tick", wdt_tick, exp_wdt());
    endtask

    task automatic load(input logic [7:0] v);
        cyc_en = 1; wr_en = 1; wr_data = v;
        step();
        wr_en = 0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_data == 8'h00, "R1 reset count", rd_data, 0);
        chk(ovf_pulse == 1'b0, "R1 reset ovf", ovf_pulse, 0);

        // R6: write then two held cycles in timer mode.
        src_sel = 0; psc_to_wdt = 1; rate = 0;
        load(8'h10);
        chk(rd_data == 8'h10, "R6 load", rd_data, 8'h10);
        step(); chk(rd_data == 8'h10, "R6 hold1", rd_data, 8'h10);
        step(); chk(rd_data == 8'h10, "R6 hold2", rd_data, 8'h10);
        step(); chk(rd_data == 8'h11, "R6 resume", rd_data, 8'h11);

        // R7: wrap from 0xFF with a single overflow pulse.
        load(8'hFE);
        step(); step();
        step(); chk(rd_data == 8'hFF, "R7 top", rd_data, 8'hFF);
        step(); chk(rd_data == 8'h00 && ovf_pulse, "R7 wrap", {ovf_pulse, rd_data}, 9'h100);
        step(); chk(!ovf_pulse, "R7 pulse width", ovf_pulse, 0);
        load(8'h00); chk(!ovf_pulse, "R7 no ovf on load", ovf_pulse, 0);

        // R3: steady pin produces nothing, a rising edge counts two edges later.
        src_sel = 1; edge_sel = 0; ext_pin = 0;
        repeat (6) step();
        chk(rd_data == 8'h00, "R3 steady pin", rd_data, 0);
        ext_pin = 1;
        step(); step(); chk(rd_data == 8'h00, "R3 sync delay", rd_data, 0);
        step(); chk(rd_data == 8'h01, "R3 rising edge", rd_data, 1);
        repeat (8) step();
        chk(rd_data == 8'h01, "R3 held high", rd_data, 1);

        // R8: counter-owned prescaler keeps the watchdog tick quiet.
        src_sel = 0; psc_to_wdt = 0; rate = 7;
        load(8'h00);
        repeat (20) begin step(); chk(!wdt_tick, "R8 quiet", wdt_tick, 0); end

        // Random phases mixing all modes, rates, gaps and writes.
        for (int ph = 0; ph < 60; ph++) begin
            src_sel    = $urandom_range(0, 1);
            edge_sel   = $urandom_range(0, 1);
            psc_to_wdt = $urandom_range(0, 1);
            rate       = (ph % 8 == 0) ? 3'd0 : (ph % 8 == 1) ? 3'd7 : 3'($urandom_range(0, 7));
            for (int c = 0; c < 600; c++) begin
                cyc_en  = ($urandom_range(0, 7) != 0);
                wr_en   = ($urandom_range(0, 63) == 0);
                wr_data = ($urandom_range(0, 3) == 0) ? 8'hFC : 8'($urandom_range(0, 255));
                if ($urandom_range(0, 5) == 0) ext_pin = ~ext_pin;
                step();
            end
            wr_en = 0;
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule